// File: doc/BRIEF.md
# Gated Up/Down Counter Timer

This block is a general-purpose event counter with a 24-bit count by default. On every active event of a chosen count source it steps its count by one. The source is one of two internal timebase tick enables or an external pin. The step is up or down, and the direction comes either from a hardware direction pin or from a control bit. The count wraps in both directions, and a terminal-count strobe marks each wrap.

A gate pin adds control by edges. Its level is sampled only at source events. When the sampled level changes in the chosen polarity, the block takes one of two programmed actions: it flips the counter between running and stopped, or it saves the present count into a holding register and raises a flag that stays set until software reads the saved value. External pins pass through two-flop synchronisers. For pads that show the selected source and the synchronised gate, the block gives an output enable that stays low until software turns it on.

Software uses a small register port with a word address. Reads are combinational. A read strobe marks a read so that the read can clear the capture flag.

Top module: `gp_counter_timer`

## Requirements
- R1: After reset the count is 0, the counter is stopped, the capture flag is clear, the control word is 0, `tc_pulse` is low and `mon_oe` is low.
- R2: The control word is at address 0. Bits [1:0] select the source: 0 is `tb_fast_tick`, 1 is `tb_slow_tick`, 2 or 3 is the external pin. While the counter runs, each cycle in which the selected source has an event steps the count by exactly one. Events of a source that is not selected have no effect. Bit 6 written as 1 makes the counter run and written as 0 stops it. A stopped counter does not step.
- R3: With the external source selected, each rising edge on `ext_src` steps the count exactly once after two synchroniser stages, however long the pin stays high.
- R4: When control bit 4 is 1, `updn_pin` sets the direction: high counts up and low counts down. When bit 4 is 0, control bit 5 sets it (1 up, 0 down) and `updn_pin` is ignored.
- R5: The count wraps modulo 2^CNT_W in both directions. `tc_pulse` is high for exactly the one cycle after each wrap, and at that cycle the count is 0 when counting up or all ones when counting down.
- R6: When control bit 3 is 0 (start/stop action), an active gate edge flips the counter between running and stopped. The source event that detects the edge still steps according to the state before the flip. Status bit 1 at address 3 reads 1 while the counter runs.
- R7: Control bit 2 selects the gate polarity: 0 acts on rising edges, 1 on falling edges. Edges of the other polarity have no effect.
- R8: When control bit 3 is 1 (capture action), an active gate edge copies the count from before that event's step into the capture register at address 2 and sets status bit 0 at address 3. Counting continues. A read of address 2 with `reg_re` high clears status bit 0.
- R9: The gate level is compared only at source events. A gate pulse that starts and ends between two source events has no effect.
- R10: A write to address 1 loads the count. A read of address 1 returns the present count.
- R11: `mon_oe` follows control bit 7. `gate_mon` shows the synchronised gate level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_fast_tick | input | 1 | Fast internal timebase tick enable |
| tb_slow_tick | input | 1 | Slow internal timebase tick enable |
| ext_src | input | 1 | External count source pin (asynchronous) |
| gate_in | input | 1 | Gate pin (asynchronous) |
| updn_pin | input | 1 | Hardware direction pin (asynchronous) |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| tc_pulse | output | 1 | One-cycle terminal-count strobe on wrap |
| mon_oe | output | 1 | Output enable for the monitor pads |
| src_mon | output | 1 | Selected source, for the monitor pad |
| gate_mon | output | 1 | Synchronised gate, for the monitor pad |

## Verification
The hardest case to reach is a gate edge that meets a source event in exactly the intended way. This covers an edge that should act, an edge of the wrong polarity, and a gate pulse that falls between two events and so must have no effect. The bench holds the gate steady for three clocks so that it passes the synchronisers. Only then does it fire a single timebase tick, so each gate transition is compared at a known event. It then reads the count and status, and checks that the step on the detecting event used the state from before the action.

// File: rtl/cntr_pkg.sv
package cntr_pkg;

    typedef enum logic [1:0] {
        SRC_FAST    = 2'd0,
        SRC_SLOW    = 2'd1,
        SRC_EXT     = 2'd2,
        SRC_EXT_ALT = 2'd3
    } src_sel_e;

    typedef enum logic {
        GATE_RISE = 1'b0,
        GATE_FALL = 1'b1
    } gate_pol_e;

    typedef enum logic {
        ACT_STARTSTOP = 1'b0,
        ACT_CAPTURE   = 1'b1
    } gate_act_e;

    // Packed MSB first: src lands in bits [1:0], mon_en in bit 7.
    typedef struct packed {
        logic      mon_en;
        logic      run;
        logic      sw_up;
        logic      hw_dir_en;
        gate_act_e act;
        gate_pol_e pol;
        src_sel_e  src;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_COUNT  = 2'd1;
    localparam logic [1:0] ADDR_CAP    = 2'd2;
    localparam logic [1:0] ADDR_STATUS = 2'd3;

    function automatic logic gate_active(gate_pol_e pol, logic now_lvl, logic ref_lvl);
        return (pol == GATE_RISE) ? (now_lvl & ~ref_lvl) : (~now_lvl & ref_lvl);
    endfunction

endpackage

// File: rtl/cntr_sync_edge.sv
module cntr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic q,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              q_d;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q_d <= 1'b0;
        else     q_d <= chain[STAGES-1];
    end

    assign q    = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~q_d;
endmodule

// File: rtl/cntr_src_mux.sv
module cntr_src_mux
    import cntr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     fast_tick,
    input  logic     slow_tick,
    input  logic     ext_pin,
    input  src_sel_e sel,
    output logic     tick,
    output logic     level
);
    logic ext_s;
    logic ext_rise;

    cntr_sync_edge #(.STAGES(SYNC_STAGES)) u_ext (
        .clk  (clk),
        .rst  (rst),
        .din  (ext_pin),
        .q    (ext_s),
        .rise (ext_rise)
    );

    always_comb begin
        unique case (sel)
            SRC_FAST: begin tick = fast_tick; level = fast_tick; end
            SRC_SLOW: begin tick = slow_tick; level = slow_tick; end
            default:  begin tick = ext_rise;  level = ext_s;     end
        endcase
    end
endmodule

// File: rtl/cntr_gate_unit.sv
module cntr_gate_unit
    import cntr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      gate_pin,
    input  logic      tick,
    input  gate_pol_e pol,
    output logic      gate_s,
    output logic      hit
);
    logic gate_ref;
    logic unused_rise;

    cntr_sync_edge #(.STAGES(SYNC_STAGES)) u_gsync (
        .clk  (clk),
        .rst  (rst),
        .din  (gate_pin),
        .q    (gate_s),
        .rise (unused_rise)
    );

    // Reference level is refreshed only at source events.
    always_ff @(posedge clk) begin
        if (rst)       gate_ref <= 1'b0;
        else if (tick) gate_ref <= gate_s;
    end

    assign hit = tick & gate_active(pol, gate_s, gate_ref);
endmodule

// File: rtl/cntr_core.sv
module cntr_core #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             up,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             tc
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] next_val;
    logic             wraps;

    always_comb begin
        next_val = up ? count + ONE : count - ONE;
        wraps    = up ? (count == ALL_ONES) : (count == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            tc    <= 1'b0;
        end else if (load_en) begin
            count <= load_val;
            tc    <= 1'b0;
        end else if (step_en) begin
            count <= next_val;
            tc    <= wraps;
        end else begin
            tc    <= 1'b0;
        end
    end
endmodule

// File: rtl/gp_counter_timer.sv
module gp_counter_timer
    import cntr_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tb_fast_tick,
    input  logic              tb_slow_tick,
    input  logic              ext_src,
    input  logic              gate_in,
    input  logic              updn_pin,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tc_pulse,
    output logic              mon_oe,
    output logic              src_mon,
    output logic              gate_mon
);
    localparam int CNT_PAD  = DATA_W - CNT_W;
    localparam int CTRL_PAD = DATA_W - CTRL_W;
    localparam int STAT_PAD = DATA_W - 2;

    ctrl_t            ctrl;
    logic             running;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cap_val;
    logic             cap_valid;
    logic             src_tick;
    logic             src_level;
    logic             gate_s;
    logic             gate_hit;
    logic             cap_hit;
    logic             toggle_hit;
    logic             dir_s;
    logic             dir_rise_unused;
    logic             count_up;
    logic             load_we;
    logic             ctrl_we;
    logic             cap_rd;
    logic [1:0]       addr_lo;

    assign addr_lo = reg_addr[1:0];
    assign ctrl_we = reg_we && (addr_lo == ADDR_CTRL);
    assign load_we = reg_we && (addr_lo == ADDR_COUNT);
    assign cap_rd  = reg_re && (addr_lo == ADDR_CAP);

    cntr_src_mux #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk       (clk),
        .rst       (rst),
        .fast_tick (tb_fast_tick),
        .slow_tick (tb_slow_tick),
        .ext_pin   (ext_src),
        .sel       (ctrl.src),
        .tick      (src_tick),
        .level     (src_level)
    );

    cntr_gate_unit #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .gate_pin (gate_in),
        .tick     (src_tick),
        .pol      (ctrl.pol),
        .gate_s   (gate_s),
        .hit      (gate_hit)
    );

    cntr_sync_edge #(.STAGES(SYNC_STAGES)) u_dir (
        .clk  (clk),
        .rst  (rst),
        .din  (updn_pin),
        .q    (dir_s),
        .rise (dir_rise_unused)
    );

    assign count_up   = ctrl.hw_dir_en ? dir_s : ctrl.sw_up;
    assign cap_hit    = gate_hit && (ctrl.act == ACT_CAPTURE);
    assign toggle_hit = gate_hit && (ctrl.act == ACT_STARTSTOP);

    cntr_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .step_en  (src_tick && running),
        .up       (count_up),
        .load_en  (load_we),
        .load_val (reg_wdata[CNT_W-1:0]),
        .count    (count),
        .tc       (tc_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            running <= 1'b0;
        end else if (ctrl_we) begin
            ctrl    <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            running <= reg_wdata[6];
        end else if (toggle_hit) begin
            running <= ~running;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_val   <= '0;
            cap_valid <= 1'b0;
        end else if (cap_hit) begin
            cap_val   <= count;
            cap_valid <= 1'b1;
        end else if (cap_rd) begin
            cap_valid <= 1'b0;
        end
    end

    always_comb begin
        unique case (addr_lo)
            ADDR_CTRL:   reg_rdata = {{CTRL_PAD{1'b0}}, ctrl};
            ADDR_COUNT:  reg_rdata = {{CNT_PAD{1'b0}}, count};
            ADDR_CAP:    reg_rdata = {{CNT_PAD{1'b0}}, cap_val};
            default:     reg_rdata = {{STAT_PAD{1'b0}}, running, cap_valid};
        endcase
    end

    assign mon_oe   = ctrl.mon_en;
    assign src_mon  = src_level;
    assign gate_mon = gate_s;
endmodule

// File: rtl/cntr_checker.sv
module cntr_checker #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             src_tick,
    input logic             running,
    input logic             load_we,
    input logic [CNT_W-1:0] count,
    input logic             tc_pulse,
    input logic             cap_valid,
    input logic             cap_hit,
    input logic             mon_oe
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (count == '0 && !running && !cap_valid && !mon_oe && !tc_pulse));

    assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!running && !load_we) |=> (count == $past(count)));

    assert_step_moves_R2: assert property (@(posedge clk) disable iff (rst)
        (running && src_tick && !load_we) |=> (count != $past(count)));

    assert_tc_single_R5: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |=> !tc_pulse);

    assert_tc_at_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |-> (count == '0 || count == ALL_ONES));

    assert_cap_source_R8: assert property (@(posedge clk) disable iff (rst)
        cap_hit |=> cap_valid);
endmodule

bind gp_counter_timer cntr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_tick  (src_tick),
    .running   (running),
    .load_we   (load_we),
    .count     (count),
    .tc_pulse  (tc_pulse),
    .cap_valid (cap_valid),
    .cap_hit   (cap_hit),
    .mon_oe    (mon_oe)
);

// File: tb/sim_gp_counter_timer.sv
`timescale 1ns/1ps
module sim_gp_counter_timer;
    localparam int CNT_W  = 24;
    localparam int DATA_W = 32;
    localparam int NV     = 6;

    localparam logic [CNT_W-1:0] V_START [NV] = '{24'd0, 24'd10, 24'hFFFFFE, 24'd1, 24'd100, 24'd7};
    localparam logic [7:0]       V_CTRL  [NV] = '{8'h60, 8'h40, 8'h60, 8'h40, 8'h20, 8'h61};
    localparam int               V_TICKS [NV] = '{5, 3, 3, 2, 4, 4};
    localparam logic [CNT_W-1:0] V_EXP   [NV] = '{24'd5, 24'd7, 24'd1, 24'hFFFFFF, 24'd100, 24'd7};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tb_fast_tick = 1'b0, tb_slow_tick = 1'b0, ext_src = 1'b0, gate_in = 1'b0, updn_pin = 1'b0;
    logic reg_we = 1'b0, reg_re = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic tc_pulse, mon_oe, src_mon, gate_mon;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    logic [DATA_W-1:0] rd;

    always #10 clk = ~clk;

    gp_counter_timer u0 (
        .clk(clk), .rst(rst), .tb_fast_tick(tb_fast_tick), .tb_slow_tick(tb_slow_tick),
        .ext_src(ext_src), .gate_in(gate_in), .updn_pin(updn_pin),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tc_pulse(tc_pulse), .mon_oe(mon_oe),
        .src_mon(src_mon), .gate_mon(gate_mon)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rdr(input logic [1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tb_fast_tick = 1'b1;
        @(negedge clk);
        tb_fast_tick = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 mon_oe", {31'd0, mon_oe}, 32'd0);
        check("R1 tc", {31'd0, tc_pulse}, 32'd0);
        rdr(2'd1, rd); check("R1 count", rd, 32'd0);
        rdr(2'd3, rd); check("R1 status", rd, 32'd0);
        rdr(2'd0, rd); check("R1 ctrl", rd, 32'd0);

        // R2 R5 R10: vector table
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, {24'd0, V_CTRL[i]});
            wr(2'd1, {8'd0, V_START[i]});
            for (int k = 0; k < V_TICKS[i]; k++) tick();
            rdr(2'd1, rd);
            check($sformatf("R2 vector %0d", i), rd, {8'd0, V_EXP[i]});
        end

        // R10 load readback
        wr(2'd1, 32'h00ABCDEF);
        rdr(2'd1, rd); check("R10 load", rd, 32'h00ABCDEF);

        // R5 terminal count pulse
        wr(2'd0, 32'h60);
        wr(2'd1, 32'h00FFFFFF);
        tick();
        check("R5 tc high", {31'd0, tc_pulse}, 32'd1);
        @(negedge clk);
        check("R5 tc one cycle", {31'd0, tc_pulse}, 32'd0);

        // R4 hardware direction
        wr(2'd0, 32'h70);
        wr(2'd1, 32'd20);
        updn_pin = 1'b0; settle();
        tick(); tick();
        rdr(2'd1, rd); check("R4 pin low down", rd, 32'd18);
        updn_pin = 1'b1; settle();
        tick();
        rdr(2'd1, rd); check("R4 pin high up", rd, 32'd19);
        wr(2'd0, 32'h40);
        tick();
        rdr(2'd1, rd); check("R4 pin ignored", rd, 32'd18);
        updn_pin = 1'b0;

        // R3 external source
        wr(2'd0, 32'h62);
        wr(2'd1, 32'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); ext_src = 1'b1;
            repeat (5) @(negedge clk);
            ext_src = 1'b0;
            repeat (4) @(negedge clk);
        end
        rdr(2'd1, rd); check("R3 ext edges", rd, 32'd3);
        repeat (3) tick();
        rdr(2'd1, rd); check("R3 fast ignored", rd, 32'd3);

        // R6 start/stop, rising polarity
        wr(2'd0, 32'h20);
        wr(2'd1, 32'd0);
        tick();
        gate_in = 1'b1; settle();
        tick();
        rdr(2'd1, rd); check("R6 start edge uses old state", rd, 32'd0);
        tick(); tick();
        gate_in = 1'b0; settle();
        tick();
        rdr(2'd1, rd); check("R7 falling ignored", rd, 32'd3);
        gate_in = 1'b1; settle();
        tick(); tick();
        rdr(2'd1, rd); check("R6 stop", rd, 32'd4);
        rdr(2'd3, rd); check("R6 status stopped", rd, 32'd0);
        gate_in = 1'b0; settle(); tick();

        // R7 falling polarity
        wr(2'd0, 32'h64);
        wr(2'd1, 32'd0);
        gate_in = 1'b1; settle();
        tick();
        rdr(2'd3, rd); check("R7 rising ignored", rd, 32'd2);
        gate_in = 1'b0; settle();
        tick(); tick();
        rdr(2'd1, rd); check("R7 falling stops", rd, 32'd2);

        // R8 capture
        wr(2'd0, 32'h68);
        wr(2'd1, 32'd50);
        tick();
        gate_in = 1'b1; settle();
        tick();
        rdr(2'd3, rd); check("R8 flag set", rd, 32'd3);
        rdr(2'd2, rd); check("R8 captured", rd, 32'd51);
        rdr(2'd3, rd); check("R8 flag cleared", rd, 32'd2);
        tick();
        rdr(2'd1, rd); check("R8 keeps counting", rd, 32'd53);
        gate_in = 1'b0; settle(); tick();

        // R9 gate pulse between events
        wr(2'd0, 32'h60);
        wr(2'd1, 32'd0);
        tick();
        gate_in = 1'b1; settle();
        gate_in = 1'b0; settle();
        tick();
        rdr(2'd1, rd); check("R9 count", rd, 32'd2);
        rdr(2'd3, rd); check("R9 still running", rd, 32'd2);

        // R11 monitor
        wr(2'd0, 32'h80);
        check("R11 oe", {31'd0, mon_oe}, 32'd1);
        gate_in = 1'b1; settle();
        check("R11 gate mon", {31'd0, gate_mon}, 32'd1);
        gate_in = 1'b0; settle();
        wr(2'd0, 32'h00);
        check("R11 oe off", {31'd0, mon_oe}, 32'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule